// File: doc/BRIEF.md
# Bypass Entry and Exit Sequencer

This block decides when a boost converter stops switching and hands its output to a low-impedance pass path from the input, and when it goes back. In automatic operation it waits for the input to exceed the output. It also waits for the output to sit at the upper hysteresis threshold and for the modulator to have produced no switching pulse for a set number of millisecond ticks. It then drives the pass device as a linear current source for a timed soft phase before turning both pass switches fully on. Automatic bypass ends when the output sags to its regulation target. While the path is fully on, an input-to-output drop comparator serves as a short-circuit detector.

A forced-bypass request overrides automatic operation. The block first waits until the output has discharged below the input, then runs the same current-limited soft phase, and then enters a full bypass. In that state it raises a low-quiescent flag and a flag that disables overcurrent, undervoltage lockout, output overvoltage and thermal protection. Dropping the request returns the sequencer to boost, from which automatic entry is qualified afresh.

States: `ST_BOOST` (switching), `ST_AUTO_SOFT` and `ST_AUTO_FULL` (automatic soft and full bypass), `ST_FORCE_WAIT`, `ST_FORCE_SOFT` and `ST_FORCE_FULL` (forced discharge wait, soft and full bypass), and `ST_FAULT`. The transitions are:
- boost→auto-soft on entry qualification.
- auto-soft→auto-full, and force-soft→force-full, on the closing tick of the soft phase.
- auto-soft/auto-full→boost on the output at target.
- auto-full→fault on an excessive drop.
- any non-fault state except the forced ones→force-wait on request.
- force-wait→force-soft once the input is above the output.
- any forced state→boost on request removal.

Top module: `bypass_ctrl`

## Requirements
- R1: After reset the sequencer is in boost, with `soft_en`, `full_en`, `low_iq`, `prot_off` and `byp_fault` all 0.
- R2: From boost, without a forced request, soft entry (`soft_en` 1) begins at the clock edge where `vin_gt_vout` and `vout_hyst_hi` are both 1 and the idle count has reached `IDLE_TICKS` (default 5) `ms_tick` pulses.
- R3: Every `sw_pulse` restarts the idle count at zero; a pulse in the same cycle as a tick wins over the tick.
- R4: A soft phase ends at the edge that samples its `SOFT_TICKS`-th (default 5) `ms_tick`, after which `full_en` is 1 and `soft_en` is 0.
- R5: In automatic soft or full bypass, `vout_at_tgt` returns the sequencer to boost (all outputs 0) at the next edge.
- R6: In automatic full bypass, `drop_hi` enters a fault: `byp_fault` 1, all switch enables 0, held until reset, with all other inputs ignored; `drop_hi` has no effect in any other state.
- R7: A forced request waits with both switch enables off until `vin_gt_vout` is 1, then runs a soft phase, then a full bypass.
- R8: `low_iq` and `prot_off` are 1 exactly in forced full bypass.
- R9: Removing `force_req` in any forced state returns to boost at the next edge.
- R10: `force_req` takes priority over every automatic transition in boost and automatic bypass states.
- R11: At most one of `soft_en`, `full_en`, `byp_fault` is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vin_gt_vout | input | 1 | Input voltage above output voltage |
| vout_at_tgt | input | 1 | Output has fallen to the regulation target |
| vout_hyst_hi | input | 1 | Output at or above target plus 25 mV |
| drop_hi | input | 1 | Input-to-output drop above 200 mV |
| sw_pulse | input | 1 | One-cycle pulse per boost switching event |
| force_req | input | 1 | Forced-bypass request |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| soft_en | output | 1 | Pass device in linear current-source mode |
| full_en | output | 1 | Both bypass switches fully enhanced |
| low_iq | output | 1 | Low-quiescent forced bypass active |
| prot_off | output | 1 | Protection circuits disabled |
| byp_fault | output | 1 | Bypass short-circuit fault |

## Verification
Every output is a decode of the state register, so the effect of inputs present at one rising edge appears just after that edge and is sampled at the following falling edge. The idle qualification adds one edge: the count reaches its limit at the edge that samples the fifth tick, and entry can happen no earlier than the next edge. The soft phase closes at the very edge that samples its fifth tick. The bench drives inputs at falling edges, advances a behavioural model at each rising edge and compares all five outputs at every falling edge, so each of these latencies is checked cycle by cycle.

// File: rtl/bpc_pkg.sv
package bpc_pkg;

    typedef enum logic [2:0] {
        ST_BOOST      = 3'd0,
        ST_AUTO_SOFT  = 3'd1,
        ST_AUTO_FULL  = 3'd2,
        ST_FORCE_WAIT = 3'd3,
        ST_FORCE_SOFT = 3'd4,
        ST_FORCE_FULL = 3'd5,
        ST_FAULT      = 3'd6
    } byp_state_e;

endpackage

// File: rtl/bpc_tick_count.sv
module bpc_tick_count #(
    parameter int LIMIT = 5,
    localparam int W = $clog2(LIMIT + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         step,
    output logic [W-1:0] cnt
);

    localparam logic [W-1:0] TOP = W'(LIMIT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (step && cnt != TOP)
            cnt <= cnt + 1'b1;
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= TOP);  // R3

endmodule

// File: rtl/bpc_fsm.sv
module bpc_fsm
    import bpc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic vin_gt_vout,
    input  logic vout_at_tgt,
    input  logic vout_hyst_hi,
    input  logic drop_hi,
    input  logic force_req,
    input  logic idle_ok,
    input  logic soft_done,
    output logic in_soft,
    output logic soft_en,
    output logic full_en,
    output logic low_iq,
    output logic prot_off,
    output logic byp_fault
);

    byp_state_e state, nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_BOOST;
        else
            state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_BOOST: begin
                if (force_req)
                    nxt = ST_FORCE_WAIT;
                else if (vin_gt_vout && vout_hyst_hi && idle_ok)
                    nxt = ST_AUTO_SOFT;
            end
            ST_AUTO_SOFT: begin
                if (force_req)
                    nxt = ST_FORCE_WAIT;
                else if (vout_at_tgt)
                    nxt = ST_BOOST;
                else if (soft_done)
                    nxt = ST_AUTO_FULL;
            end
            ST_AUTO_FULL: begin
                if (force_req)
                    nxt = ST_FORCE_WAIT;
                else if (drop_hi)
                    nxt = ST_FAULT;
                else if (vout_at_tgt)
                    nxt = ST_BOOST;
            end
            ST_FORCE_WAIT: begin
                if (!force_req)
                    nxt = ST_BOOST;
                else if (vin_gt_vout)
                    nxt = ST_FORCE_SOFT;
            end
            ST_FORCE_SOFT: begin
                if (!force_req)
                    nxt = ST_BOOST;
                else if (soft_done)
                    nxt = ST_FORCE_FULL;
            end
            ST_FORCE_FULL: begin
                if (!force_req)
                    nxt = ST_BOOST;
            end
            ST_FAULT: nxt = ST_FAULT;
            default:  nxt = ST_BOOST;
        endcase
    end

    always_comb begin
        in_soft   = (state == ST_AUTO_SOFT) || (state == ST_FORCE_SOFT);
        soft_en   = in_soft;
        full_en   = (state == ST_AUTO_FULL) || (state == ST_FORCE_FULL);
        low_iq    = (state == ST_FORCE_FULL);
        prot_off  = (state == ST_FORCE_FULL);
        byp_fault = (state == ST_FAULT);
    end

    AST_ONE_PATH: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({soft_en, full_en, byp_fault}));  // R11

    AST_FAULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        byp_fault |=> byp_fault);  // R6

    AST_FAULT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(byp_fault) |-> $past(drop_hi && full_en && !force_req));  // R6

    AST_FULL_AFTER_SOFT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(full_en) |-> $past(soft_en));  // R4

    AST_AUTO_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_en && !$past(soft_en) && !$past(force_req))
            |-> $past(idle_ok && vin_gt_vout && vout_hyst_hi));  // R2

    AST_RELEASE_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
        (low_iq && !force_req) |=> !low_iq);  // R9

endmodule

// File: rtl/bypass_ctrl.sv
module bypass_ctrl #(
    parameter int IDLE_TICKS = 5,
    parameter int SOFT_TICKS = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vin_gt_vout,
    input  logic vout_at_tgt,
    input  logic vout_hyst_hi,
    input  logic drop_hi,
    input  logic sw_pulse,
    input  logic force_req,
    input  logic ms_tick,
    output logic soft_en,
    output logic full_en,
    output logic low_iq,
    output logic prot_off,
    output logic byp_fault
);

    localparam int IW = $clog2(IDLE_TICKS + 1);
    localparam int SW = $clog2(SOFT_TICKS + 1);

    logic [IW-1:0] idle_cnt;
    logic [SW-1:0] soft_cnt;
    logic          in_soft;
    logic          idle_ok;
    logic          soft_done;

    bpc_tick_count #(.LIMIT(IDLE_TICKS)) u_idle (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (sw_pulse),
        .step  (ms_tick),
        .cnt   (idle_cnt)
    );

    bpc_tick_count #(.LIMIT(SOFT_TICKS)) u_soft (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!in_soft),
        .step  (ms_tick),
        .cnt   (soft_cnt)
    );

    assign idle_ok   = (idle_cnt == IW'(IDLE_TICKS));
    assign soft_done = in_soft && ms_tick && (soft_cnt == SW'(SOFT_TICKS - 1));

    bpc_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .vin_gt_vout  (vin_gt_vout),
        .vout_at_tgt  (vout_at_tgt),
        .vout_hyst_hi (vout_hyst_hi),
        .drop_hi      (drop_hi),
        .force_req    (force_req),
        .idle_ok      (idle_ok),
        .soft_done    (soft_done),
        .in_soft      (in_soft),
        .soft_en      (soft_en),
        .full_en      (full_en),
        .low_iq       (low_iq),
        .prot_off     (prot_off),
        .byp_fault    (byp_fault)
    );

endmodule

// File: tb/bypass_ctrl_test.sv
module bypass_ctrl_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic vin_gt_vout = 1'b0, vout_at_tgt = 1'b0, vout_hyst_hi = 1'b0;
    logic drop_hi = 1'b0, sw_pulse = 1'b0, force_req = 1'b0, ms_tick = 1'b0;
    logic soft_en, full_en, low_iq, prot_off, byp_fault;

    always #4 clk = ~clk;

    bypass_ctrl uut (
        .clk(clk), .rst_n(rst_n), .vin_gt_vout(vin_gt_vout), .vout_at_tgt(vout_at_tgt),
        .vout_hyst_hi(vout_hyst_hi), .drop_hi(drop_hi), .sw_pulse(sw_pulse),
        .force_req(force_req), .ms_tick(ms_tick), .soft_en(soft_en), .full_en(full_en),
        .low_iq(low_iq), .prot_off(prot_off), .byp_fault(byp_fault)
    );

    // model: 0 boost,1 auto soft,2 auto full,3 force wait,4 force soft,5 force full,6 fault
    int m_st = 0, m_idle = 0, m_soft = 0;
    int n_cmp = 0, n_bad = 0, cyc = 0;
    string req = "R1";

    always @(posedge clk) begin
        int nx;
        bit insoft, done;
        if (!rst_n) begin
            m_st = 0; m_idle = 0; m_soft = 0;
        end else begin
            insoft = (m_st == 1) || (m_st == 4);
            done = insoft && ms_tick && (m_soft == 4);
            nx = m_st;
            case (m_st)
                0: if (force_req) nx = 3;
                   else if (vin_gt_vout && vout_hyst_hi && m_idle == 5) nx = 1;
                1: if (force_req) nx = 3; else if (vout_at_tgt) nx = 0; else if (done) nx = 2;
                2: if (force_req) nx = 3; else if (drop_hi) nx = 6; else if (vout_at_tgt) nx = 0;
                3: if (!force_req) nx = 0; else if (vin_gt_vout) nx = 4;
                4: if (!force_req) nx = 0; else if (done) nx = 5;
                5: if (!force_req) nx = 0;
                default: nx = 6;
            endcase
            if (sw_pulse) m_idle = 0;
            else if (ms_tick && m_idle < 5) m_idle++;
            if (!insoft) m_soft = 0;
            else if (ms_tick && m_soft < 5) m_soft++;
            m_st = nx;
        end
    end

    task automatic cmp1(string nm, logic act, logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b (cycle %0d)", req, nm, act, exp, cyc);
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        cmp1("soft_en", soft_en, m_st == 1 || m_st == 4);
        cmp1("full_en", full_en, m_st == 2 || m_st == 5);
        cmp1("low_iq", low_iq, m_st == 5);
        cmp1("prot_off", prot_off, m_st == 5);
        cmp1("byp_fault", byp_fault, m_st == 6);
        if (cyc > 50000) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic tick(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); ms_tick = 1'b1;
            @(negedge clk); ms_tick = 1'b0;
            idle(2);
        end
    endtask

    task automatic pulse_sw();
        @(negedge clk); sw_pulse = 1'b1;
        @(negedge clk); sw_pulse = 1'b0;
    endtask

    initial begin
        req = "R1"; idle(4);
        @(negedge clk); rst_n = 1'b1;
        idle(3);
        // R2 / R3: idle qualification and restart on switching pulses
        req = "R3"; vin_gt_vout = 1'b1; vout_hyst_hi = 1'b1;
        tick(3); pulse_sw(); tick(4);
        @(negedge clk); sw_pulse = 1'b1; ms_tick = 1'b1;
        @(negedge clk); sw_pulse = 1'b0; ms_tick = 1'b0;
        tick(4); idle(3);
        req = "R2"; tick(1); idle(3);
        // R4: soft phase length
        req = "R4"; tick(5); idle(3);
        // R5: exit from full
        req = "R5"; vout_hyst_hi = 1'b0;
        @(negedge clk); vout_at_tgt = 1'b1;
        @(negedge clk); vout_at_tgt = 1'b0;
        idle(3);
        // R5: exit from soft (idle still qualified)
        vout_hyst_hi = 1'b1; idle(3); tick(2);
        @(negedge clk); vout_at_tgt = 1'b1;
        @(negedge clk); vout_at_tgt = 1'b0;
        idle(2); vout_hyst_hi = 1'b0; idle(2);
        // R6 ignored in boost
        req = "R6"; drop_hi = 1'b1; idle(3); drop_hi = 1'b0;
        // R10: force overrides auto full
        vout_hyst_hi = 1'b1; idle(2); tick(5);
        req = "R10"; @(negedge clk); force_req = 1'b1; vout_at_tgt = 1'b1;
        @(negedge clk); vout_at_tgt = 1'b0;
        // R7: wait for discharge
        req = "R7"; vin_gt_vout = 1'b0; vout_hyst_hi = 1'b0; tick(3);
        vin_gt_vout = 1'b1; idle(2); tick(5); idle(2);
        // R8 / R6: forced full, drop ignored
        req = "R8"; drop_hi = 1'b1; idle(4); drop_hi = 1'b0; tick(2);
        // R9: release
        req = "R9"; force_req = 1'b0; idle(4);
        // R9 from wait and soft
        force_req = 1'b1; vin_gt_vout = 1'b0; idle(3); force_req = 1'b0; idle(2);
        force_req = 1'b1; vin_gt_vout = 1'b1; idle(2); tick(2); force_req = 1'b0; idle(3);
        // R6: short circuit fault, sticky
        req = "R6"; vout_hyst_hi = 1'b1; tick(6);
        @(negedge clk); drop_hi = 1'b1;
        @(negedge clk); drop_hi = 1'b0;
        vout_at_tgt = 1'b1; force_req = 1'b1; tick(2);
        vout_at_tgt = 1'b0; force_req = 1'b0; idle(3);
        // R11 checked throughout; R1 again
        req = "R1"; @(negedge clk); rst_n = 1'b0; idle(3);
        rst_n = 1'b1; vin_gt_vout = 1'b0; vout_hyst_hi = 1'b0; idle(3);
        req = "R11"; idle(2);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule